// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address side of one DMA channel. Software programs an 8-bit control word, a 24-bit start address and a transfer count through a small register port, then sets the channel enable. Each one-cycle completion strobe from the data mover advances the address by the transfer size (1 for bytes, 2 for words), upward or downward. It also decrements the count. The count reaching zero ends the block.

The channel has three operating modes, chosen by the control word's repeat bit together with an external interrupt-enable input. Sequential mode steps the address and stops at the end of the block, raising an interrupt only if interrupts are enabled. Repeat mode reloads the start address and count at the end of the block and keeps running without an interrupt. Idle mode holds the address fixed, stops at the end of the block and always raises the interrupt. Arbitration, data movement and channel priority belong to other blocks.

Register map, selected by `reg_sel` for writes and `rd_sel` for reads:

| Select | Write | Read |
|---|---|---|
| 0 | control word from bits 7:0 | control word, zero-extended |
| 1 | start address, loaded into the working address and a reload copy | working address |
| 2 | transfer count, loaded into the working count and a reload copy | working count |
| 3 | bit 0 sets the channel enable; bit 1 = 1 clears the interrupt flag | bit 0 is the enable, bit 1 is the flag |

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, the control word reads 0x00, the address reads 0, the count reads 0, the status reads 0 and `irq` is low.
- R2: A cycle with `standby` high clears the control word to 0x00, with priority over a write in the same cycle.
- R3: With control bit 7 = 0 (byte size) and bit 6 = 0 (upward), each accepted strobe adds 1 to the address.
- R4: With control bit 7 = 1 (word size), each accepted strobe moves the address by 2.
- R5: With control bit 6 = 1, each accepted strobe subtracts the step from the address. The address wraps modulo 2^24.
- R6: With control bit 5 = 0 (sequential mode), the strobe that takes the count from 1 to 0 clears the enable. It sets the interrupt flag only if `xfer_ie` is 1.
- R7: With control bit 5 = 1 and `xfer_ie` = 0 (repeat mode), the strobe that takes the count from 1 to 0 instead reloads the address and count from their reload copies. The channel stays enabled and no interrupt flag is set.
- R8: With control bit 5 = 1 and `xfer_ie` = 1 (idle mode), accepted strobes leave the address unchanged. The final strobe clears the enable and sets the interrupt flag.
- R9: A strobe while the enable is 0 changes neither the address nor the count.
- R10: The interrupt flag drives `irq`. It stays set until a status write with bit 1 = 1 clears it.
- R11: All 8 bits of the control word, including the 4-bit transfer-factor field in bits 3:0 and bit 4, are written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Clears the control word while high |
| xfer_ie | input | 1 | Transfer-end interrupt enable; also selects idle against repeat mode |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selected for the write |
| reg_wdata | input | 24 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 24 | Read data, combinational from `rd_sel` |
| xfer_done | input | 1 | One-cycle strobe for a completed data transfer |
| cur_addr | output | 24 | Working memory address |
| irq | output | 1 | Transfer-end interrupt request (the sticky flag) |

## Verification
On every cycle, the assertions check that standby clears the control word and that a disabled channel's address stays put. They also check that idle mode holds the address, that a non-repeat block end drops the enable, that a repeat block end restores the count, and that the interrupt flag is sticky. Only the bench scenarios can show the actual address values. These cover the exact byte and word steps, downward wrap through zero, the reload value after a repeat block, and readback of every control bit. The bench runs the modes in turn and compares each strobe's resulting address and `irq` against a scoreboard filled by an independent model.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA channel address sequencer.
// Assumes: control word layout is fixed at 8 bits; select codes are 2 bits.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ  = 2'd0,
        MODE_RPT  = 2'd1,
        MODE_IDLE = 2'd2
    } chan_mode_e;

    typedef struct packed {
        logic       wide;    // bit 7: word-size transfer
        logic       down;    // bit 6: address moves downward
        logic       rpt;     // bit 5: repeat enable
        logic       spare;   // bit 4: stored, no function
        logic [3:0] factor;  // bits 3:0: transfer-factor field
    } ctrl_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    // Mode from repeat bit and external interrupt enable.
    function automatic chan_mode_e decode_mode(input logic rpt, input logic ie);
        if (!rpt)    return MODE_SEQ;
        else if (ie) return MODE_IDLE;
        else         return MODE_RPT;
    endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
// Control word register with mode decode.
// Does: holds the 8-bit control word, cleared by reset or standby, and
//       decodes the operating mode from the repeat bit and xfer_ie.
// Assumes: standby outranks a same-cycle write.
module dma_ctrl_reg
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       ie,
    output ctrl_t      ctrl_q,
    output chan_mode_e mode
);

    // Control word storage: reset and standby clear, else write.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) ctrl_q <= '0;
        else if (we)           ctrl_q <= ctrl_t'(wdata);
    end

    // Mode decode from the stored repeat bit and the live enable input.
    always_comb mode = decode_mode(ctrl_q.rpt, ie);

    // R2
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctrl_q == '0));

endmodule

// File: rtl/dma_addr_unit.sv
// Working address register with reload copy.
// Does: loads start address (working and reload copy), steps by 1 or 2
//       up or down per accepted strobe, holds in idle mode, and restores
//       the reload copy at a repeat-mode block end.
// Assumes: a register load outranks a same-cycle strobe; wraps mod 2^ADDR_W.
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              block_end,
    input  chan_mode_e        mode,
    input  logic              wide,
    input  logic              down,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int PAD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] reload_q;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] stepped;

    // Stride is 2 for words, 1 for bytes.
    always_comb stride = {{PAD_W{1'b0}}, wide, ~wide};

    // Next address after one transfer in the chosen direction.
    always_comb stepped = down ? (addr_q - stride) : (addr_q + stride);

    // Reload copy captures each programmed start address.
    always_ff @(posedge clk) begin
        if (!rst_n)    reload_q <= '0;
        else if (load) reload_q <= load_val;
    end

    // Working address: load, repeat restore, step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                           addr_q <= '0;
        else if (load)                        addr_q <= load_val;
        else if (step) begin
            if (block_end && mode == MODE_RPT) addr_q <= reload_q;
            else if (mode != MODE_IDLE)        addr_q <= stepped;
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == MODE_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/dma_xfer_counter.sv
// Transfer counter with reload copy.
// Does: loads a count (working and reload copy), decrements per accepted
//       strobe, flags the 1-to-0 step as block end, and restores the
//       reload copy instead in repeat mode.
// Assumes: a register load outranks a same-cycle strobe; a zero count
//          wraps on a strobe without signalling block end.
module dma_xfer_counter
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  chan_mode_e       mode,
    output logic [CNT_W-1:0] cnt_q,
    output logic             block_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload_q;

    // Block end is the strobe that takes the count from 1 to 0.
    always_comb block_end = step && (cnt_q == ONE);

    // Reload copy captures each programmed count.
    always_ff @(posedge clk) begin
        if (!rst_n)    reload_q <= '0;
        else if (load) reload_q <= load_val;
    end

    // Working count: load, repeat restore, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (load)                          cnt_q <= load_val;
        else if (block_end && mode == MODE_RPT) cnt_q <= reload_q;
        else if (step)                          cnt_q <= cnt_q - ONE;
    end

    // R7
    rpt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end && !load && mode == MODE_RPT) |=> (cnt_q == $past(reload_q)));

endmodule

// File: rtl/dma_addr_seq.sv
// DMA channel address sequencer, top level.
// Does: register port, channel enable, sticky interrupt flag, and wiring
//       of control, address and counter units.
// Assumes: reg_wdata is as wide as the address; count width <= address width.
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              xfer_ie,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              irq
);

    localparam int CTRL_PAD = ADDR_W - 8;
    localparam int CNT_PAD  = ADDR_W - CNT_W;
    localparam int STAT_PAD = ADDR_W - 2;

    ctrl_t            ctrl_q;
    chan_mode_e       mode;
    logic             chan_en;
    logic             irq_flag;
    logic             step;
    logic             block_end;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl, wr_addr, wr_cnt, wr_stat;

    // Write decode per register.
    always_comb begin
        wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
        wr_addr = reg_we && (reg_sel == SEL_ADDR);
        wr_cnt  = reg_we && (reg_sel == SEL_CNT);
        wr_stat = reg_we && (reg_sel == SEL_STAT);
    end

    // A strobe counts only while the channel is enabled.
    always_comb step = xfer_done && chan_en;

    dma_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .standby(standby),
        .we     (wr_ctrl),
        .wdata  (reg_wdata[7:0]),
        .ie     (xfer_ie),
        .ctrl_q (ctrl_q),
        .mode   (mode)
    );

    dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_addr),
        .load_val (reg_wdata),
        .step     (step),
        .block_end(block_end),
        .mode     (mode),
        .wide     (ctrl_q.wide),
        .down     (ctrl_q.down),
        .addr_q   (cur_addr)
    );

    dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .step     (step),
        .mode     (mode),
        .cnt_q    (cnt_q),
        .block_end(block_end)
    );

    // Channel enable: set by status write, dropped at a non-repeat block end.
    always_ff @(posedge clk) begin
        if (!rst_n)                              chan_en <= 1'b0;
        else if (wr_stat)                        chan_en <= reg_wdata[0];
        else if (block_end && mode != MODE_RPT)  chan_en <= 1'b0;
    end

    // Sticky interrupt flag: write-one clears, enabled non-repeat end sets.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          irq_flag <= 1'b0;
        else if (wr_stat && reg_wdata[1])                    irq_flag <= 1'b0;
        else if (block_end && mode != MODE_RPT && xfer_ie)   irq_flag <= 1'b1;
    end

    always_comb irq = irq_flag;

    // Read multiplexer over the four registers.
    always_comb begin
        unique case (rd_sel)
            SEL_CTRL: rd_data = {{CTRL_PAD{1'b0}}, ctrl_q};
            SEL_ADDR: rd_data = cur_addr;
            SEL_CNT:  rd_data = {{CNT_PAD{1'b0}}, cnt_q};
            default:  rd_data = {{STAT_PAD{1'b0}}, irq_flag, chan_en};
        endcase
    end

    // R9
    parked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !wr_addr) |=> $stable(cur_addr));

    // R6
    block_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end && mode != MODE_RPT && !wr_stat) |=> !chan_en);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(wr_stat && reg_wdata[1])) |=> irq_flag);

endmodule

// File: tb/dma_addr_seq_tb.sv
// Scoreboard bench: the strobe driver pushes expected address/irq items from
// an independent model; a monitor pops and compares after each strobe.
module dma_addr_seq_tb;

    typedef struct packed {
        logic [23:0] addr;
        logic        irq;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        standby = 0;
    logic        xfer_ie = 0;
    logic        reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [23:0] reg_wdata = 0;
    logic [1:0]  rd_sel = 0;
    logic [23:0] rd_data;
    logic        xfer_done = 0;
    logic [23:0] cur_addr;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;
    exp_t sb[$];
    string tag_q[$];
    logic strobe_d = 0;

    // Model state.
    logic [23:0] m_addr = 0, m_sha = 0;
    logic [15:0] m_cnt = 0, m_shc = 0;
    logic [7:0]  m_ctrl = 0;
    logic        m_en = 0, m_flag = 0;

    always #4 clk = ~clk;

    dma_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .xfer_ie(xfer_ie),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_done(xfer_done),
        .cur_addr(cur_addr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [23:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        case (sel)
            2'd0: m_ctrl = d[7:0];
            2'd1: begin m_addr = d; m_sha = d; end
            2'd2: begin m_cnt = d[15:0]; m_shc = d[15:0]; end
            default: begin m_en = d[0]; if (d[1]) m_flag = 0; end
        endcase
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [23:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // Driver: model one strobe from the requirements, push the expectation.
    task automatic pulse(input string tag);
        logic last;
        logic [23:0] stp;
        exp_t e;
        if (m_en) begin
            last = (m_cnt == 16'd1);
            stp  = m_ctrl[7] ? 24'd2 : 24'd1;
            if (m_ctrl[5] && !xfer_ie && last) begin
                m_addr = m_sha; m_cnt = m_shc;
            end else begin
                if (!(m_ctrl[5] && xfer_ie))
                    m_addr = m_ctrl[6] ? m_addr - stp : m_addr + stp;
                m_cnt = m_cnt - 16'd1;
                if (last) begin
                    m_en = 0;
                    if (xfer_ie) m_flag = 1;
                end
            end
        end
        e.addr = m_addr; e.irq = m_flag;
        sb.push_back(e);
        tag_q.push_back(tag);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
    endtask

    always @(posedge clk) strobe_d <= xfer_done;

    // Monitor: one comparison per strobe, one edge after it was sampled.
    always @(negedge clk) begin
        if (strobe_d && sb.size() > 0) begin
            exp_t e;
            string t;
            e = sb.pop_front();
            t = tag_q.pop_front();
            chk({t, " addr"}, cur_addr, e.addr);
            chk({t, " irq"}, {23'd0, irq}, {23'd0, e.irq});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 24'h0);
        rd_chk("R1 addr", 2'd1, 24'h0);
        rd_chk("R1 cnt", 2'd2, 24'h0);
        rd_chk("R1 status", 2'd3, 24'h0);
        chk("R1 irq", {23'd0, irq}, 24'h0);

        // R11 full control readback, R2 standby clear
        wr(2'd0, 24'h00005A);
        rd_chk("R11 ctrl 5A", 2'd0, 24'h5A);
        wr(2'd0, 24'h0000B7);
        rd_chk("R11 ctrl B7", 2'd0, 24'hB7);
        standby = 1;
        @(negedge clk);
        standby = 0;
        m_ctrl = 0;
        rd_chk("R2 standby clear", 2'd0, 24'h0);

        // R3 sequential byte upward, no interrupt (R6 ie=0)
        xfer_ie = 0;
        wr(2'd0, 24'h00);
        wr(2'd1, 24'h000100);
        wr(2'd2, 24'd3);
        wr(2'd3, 24'h1);
        pulse("R3 step1");
        pulse("R3 step2");
        pulse("R6 seq end");
        rd_chk("R6 enable cleared", 2'd3, 24'h0);
        rd_chk("R6 count zero", 2'd2, 24'h0);
        // R9 strobes while disabled
        pulse("R9 parked");
        pulse("R9 parked2");
        rd_chk("R9 count held", 2'd2, 24'h0);

        // R4/R5 word downward with wrap, interrupt on end (R6 ie=1)
        xfer_ie = 1;
        wr(2'd0, 24'hC0);
        wr(2'd1, 24'h000001);
        wr(2'd2, 24'd2);
        wr(2'd3, 24'h1);
        pulse("R5 wrap");
        pulse("R4 word down end");
        rd_chk("R6 flag set, disabled", 2'd3, 24'h2);
        repeat (4) @(negedge clk);
        chk("R10 sticky", {23'd0, irq}, 24'h1);
        wr(2'd3, 24'h2);
        chk("R10 cleared", {23'd0, irq}, 24'h0);

        // R7 repeat mode: word upward, reload on block end
        xfer_ie = 0;
        wr(2'd0, 24'hA0);
        wr(2'd1, 24'h000010);
        wr(2'd2, 24'd2);
        wr(2'd3, 24'h1);
        pulse("R4 rpt step");
        pulse("R7 reload");
        rd_chk("R7 count reloaded", 2'd2, 24'd2);
        rd_chk("R7 still enabled", 2'd3, 24'h1);
        pulse("R7 after reload");

        // R8 idle mode: address fixed, interrupt at end
        xfer_ie = 1;
        wr(2'd3, 24'h0);
        wr(2'd0, 24'h20);
        wr(2'd1, 24'h000500);
        wr(2'd2, 24'd2);
        wr(2'd3, 24'h1);
        pulse("R8 hold");
        pulse("R8 end");
        rd_chk("R8 enable cleared", 2'd3, 24'h2);

        @(negedge clk);
        chk("scoreboard drained", 24'(sb.size()), 24'd0);
        done_run = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule